// File: doc/BRIEF.md
# Pseudo-Random Pattern Receive Checker

This block watches a recovered NRZ bit stream, one bit per clock qualified by a valid strobe, and checks it against an unframed pseudo-random test pattern. Every valid bit counts as a pattern bit, because the stream carries no framing or overhead bits. The detector searches all the time and needs no start command. It loads its prediction register from the incoming bits and qualifies a candidate alignment. Once it is locked, it reports every bit that differs from the expected sequence.

The line-mode input sets the pattern length. The E3 mode uses the 2^23−1 sequence and the T3 and STS-1 modes use the 2^15−1 sequence. The block has one combined status line, which is high while the detector is hunting and low while it is locked, with a one-clock high pulse for each errored bit. It also provides a sync flag and a saturating error counter. When the feature enable is low, the status line is driven to zero and its output enable is dropped, so the pad can be put in tristate.

The controller has three states. ST_FILL shifts received bits into the prediction register until it holds one full pattern length. ST_VERIFY compares each prediction with the received bit and counts consecutive matches. ST_LOCK lets the register run on its own predictions and counts errors in a sliding window. The transitions are as follows:
- fill_done (ST_FILL to ST_VERIFY).
- qualify (ST_VERIFY to ST_LOCK).
- miss (ST_VERIFY to ST_VERIFY, which restarts the run).
- lose (ST_LOCK to ST_FILL).
- mode_change (any state to ST_FILL).

Top module: `prbs_rx_check`

## Requirements
- R1: `line_mode_i` = 2'b00 (E3) selects the long recurrence b[n] = NOT(b[n−23] XOR b[n−18]). The codes 2'b01 (T3), 2'b10 (STS-1) and 2'b11 select the short recurrence b[n] = NOT(b[n−15] XOR b[n−14]). A stream that follows the other recurrence never brings `sync_o` high.
- R2: After reset, a mode change or a loss of sync, the first LEN valid bits only load the register, where LEN is 15 or 23. `sync_o` rises right after the clock edge that accepts the 32nd consecutive correctly predicted bit that follows them, that is the (LEN+32)-th valid bit.
- R3: A mismatch during qualification restarts the run of 32. The bad bit has been loaded into the register, so the predictions for the bits at distances 14 and 15 after it (short mode) also fail. Lock then follows 32 bits after the later of those two.
- R4: A qualifying run of 32 bits that contains no zero bit does not lock, so an all-ones stream never raises `sync_o`.
- R5: While `sync_o` is low and `en_i` is high, `stat_o` is held high.
- R6: While locked, `stat_o` is low, except that it is high for exactly the one clock after the edge that accepts a bit differing from the prediction.
- R7: While locked, the register runs on its own predictions, so a single corrupted bit produces exactly one error and no further ones.
- R8: Sync is lost at the edge of the valid bit that brings the number of errors among the last 64 valid bits to 6. Six errors spread over 65 valid bits do not cause a loss.
- R9: A change of `line_mode_i` drops `sync_o` at the next clock edge and restarts the search.
- R10: With `en_i` low, `stat_o` and `stat_oe_o` are both 0. Detection and counting carry on unaffected.
- R11: `err_cnt_o` counts errored bits while locked, holds at all ones, and is cleared to 0 by the edge at which `cnt_clr_i` is high.
- R12: Cycles with `valid_i` low do not advance the pattern, change the sync state or count errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_mode_i | input | 2 | Line mode: 00 E3, 01 T3, 10 STS-1, 11 treated as short |
| en_i | input | 1 | Feature enable for the status output |
| valid_i | input | 1 | Qualifies `data_i` for this clock |
| data_i | input | 1 | Recovered NRZ data bit |
| cnt_clr_i | input | 1 | Synchronous clear of the error counter |
| stat_o | output | 1 | Combined status: high out of sync, pulse per error when locked |
| stat_oe_o | output | 1 | Output enable for the status pad |
| sync_o | output | 1 | High while locked to the pattern |
| err_cnt_o | output | CNT_W | Saturating count of errored bits |

## Verification
The bench builds the block with `CNT_W` = 3. This lets a handful of injected errors reach counter saturation and check that the counter holds there. The window and run lengths keep their defaults of 64, 6 and 32. The bench can therefore count the exact bit at which lock is declared in both pattern lengths. It also sweeps the span of a six-error burst from 60 to 68 bits, which crosses the loss boundary at 64 from both sides.

// File: rtl/prbs_rx_pkg.sv
package prbs_rx_pkg;

    typedef enum logic [1:0] {
        MODE_E3   = 2'b00,
        MODE_T3   = 2'b01,
        MODE_STS1 = 2'b10,
        MODE_RSVD = 2'b11
    } line_mode_e;

    typedef enum logic [1:0] {
        ST_FILL   = 2'b00,
        ST_VERIFY = 2'b01,
        ST_LOCK   = 2'b10
    } chk_state_e;

endpackage

// File: rtl/prbs_rx_predict.sv
module prbs_rx_predict #(
    parameter int SHORT_LEN = 15,
    parameter int SHORT_TAP = 14,
    parameter int LONG_LEN  = 23,
    parameter int LONG_TAP  = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic long_sel,
    input  logic shift_en,
    input  logic take_data,
    input  logic data_in,
    output logic pred
);
    localparam int REG_W = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;

    logic [REG_W-1:0] hist_q;
    logic             pred_short;
    logic             pred_long;

    // hist_q[k] holds the bit received k+1 positions ago
    assign pred_short = ~(hist_q[SHORT_LEN-1] ^ hist_q[SHORT_TAP-1]);
    assign pred_long  = ~(hist_q[LONG_LEN-1]  ^ hist_q[LONG_TAP-1]);
    assign pred       = long_sel ? pred_long : pred_short;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[REG_W-2:0], (take_data ? data_in : pred)};
        end
    end

endmodule

// File: rtl/prbs_rx_window.sv
module prbs_rx_window #(
    parameter int WIN   = 64,
    parameter int LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic err_in,
    output logic lose
);
    localparam int CW = $clog2(WIN + 1);

    logic [WIN-1:0] flags_q;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  cnt_nx;

    // errors among the newest WIN bits once this bit joins and the oldest leaves
    always_comb begin
        cnt_nx = cnt_q + CW'(err_in) - CW'(flags_q[WIN-1]);
    end

    assign lose = step && (cnt_nx >= CW'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            cnt_q   <= '0;
        end else if (clr) begin
            flags_q <= '0;
            cnt_q   <= '0;
        end else if (step) begin
            flags_q <= {flags_q[WIN-2:0], err_in};
            cnt_q   <= cnt_nx;
        end
    end

endmodule

// File: rtl/prbs_rx_errcnt.sv
module prbs_rx_errcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q;
    logic         full;

    assign full = &cnt_q;
    assign cnt  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && !full) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/prbs_rx_check.sv
module prbs_rx_check
    import prbs_rx_pkg::*;
#(
    parameter int SHORT_LEN = 15,
    parameter int SHORT_TAP = 14,
    parameter int LONG_LEN  = 23,
    parameter int LONG_TAP  = 18,
    parameter int SYNC_RUN  = 32,
    parameter int LOSS_WIN  = 64,
    parameter int LOSS_ERRS = 6,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       line_mode_i,
    input  logic             en_i,
    input  logic             valid_i,
    input  logic             data_i,
    input  logic             cnt_clr_i,
    output logic             stat_o,
    output logic             stat_oe_o,
    output logic             sync_o,
    output logic [CNT_W-1:0] err_cnt_o
);
    localparam int REG_W = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
    localparam int FW    = $clog2(REG_W + 1);
    localparam int RW    = $clog2(SYNC_RUN + 1);
    localparam logic [FW-1:0] SHORT_LAST = FW'(SHORT_LEN - 1);
    localparam logic [FW-1:0] LONG_LAST  = FW'(LONG_LEN - 1);
    localparam logic [RW-1:0] RUN_LAST   = RW'(SYNC_RUN - 1);

    chk_state_e    state_q, state_d;
    line_mode_e    mode_q;
    logic [FW-1:0] fill_cnt_q;
    logic [RW-1:0] run_cnt_q;
    logic          saw_zero_q;
    logic          sync_q;
    logic          err_q;

    logic          mode_chg;
    logic          long_sel;
    logic [FW-1:0] fill_last;
    logic          pred;
    logic          mismatch;
    logic          bit_err;
    logic          lose;
    logic          run_full;
    logic          qualify;

    assign mode_chg  = (line_mode_i != mode_q);
    assign long_sel  = (line_mode_i == MODE_E3);
    assign fill_last = long_sel ? LONG_LAST : SHORT_LAST;
    assign mismatch  = data_i ^ pred;
    assign bit_err   = (state_q == ST_LOCK) && valid_i && mismatch && !mode_chg;
    assign run_full  = (run_cnt_q == RUN_LAST) && !mismatch;
    assign qualify   = run_full && (saw_zero_q || !data_i);

    prbs_rx_predict #(
        .SHORT_LEN (SHORT_LEN),
        .SHORT_TAP (SHORT_TAP),
        .LONG_LEN  (LONG_LEN),
        .LONG_TAP  (LONG_TAP)
    ) pred_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .long_sel  (long_sel),
        .shift_en  (valid_i),
        .take_data ((state_q != ST_LOCK) || mode_chg),
        .data_in   (data_i),
        .pred      (pred)
    );

    prbs_rx_window #(
        .WIN   (LOSS_WIN),
        .LIMIT (LOSS_ERRS)
    ) win_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_q != ST_LOCK),
        .step   ((state_q == ST_LOCK) && valid_i && !mode_chg),
        .err_in (mismatch),
        .lose   (lose)
    );

    prbs_rx_errcnt #(
        .W (CNT_W)
    ) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr_i),
        .inc   (bit_err),
        .cnt   (err_cnt_o)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (mode_chg) begin
            state_d = ST_FILL;                        // mode_change
        end else if (valid_i) begin
            unique case (state_q)
                ST_FILL:   if (fill_cnt_q >= fill_last) state_d = ST_VERIFY;  // fill_done
                ST_VERIFY: if (qualify) state_d = ST_LOCK;                     // qualify
                ST_LOCK:   if (lose) state_d = ST_FILL;                        // lose
                default:   state_d = ST_FILL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // counters and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_T3;
            fill_cnt_q <= '0;
            run_cnt_q  <= '0;
            saw_zero_q <= 1'b0;
            sync_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            mode_q <= line_mode_e'(line_mode_i);
            sync_q <= (state_d == ST_LOCK);
            err_q  <= bit_err;
            if (mode_chg || (state_d != state_q)) begin
                fill_cnt_q <= '0;
                run_cnt_q  <= '0;
                saw_zero_q <= 1'b0;
            end else if (valid_i) begin
                unique case (state_q)
                    ST_FILL: begin
                        fill_cnt_q <= fill_cnt_q + FW'(1);
                    end
                    ST_VERIFY: begin
                        if (mismatch || run_full) begin   // miss, or zero-free run
                            run_cnt_q  <= '0;
                            saw_zero_q <= 1'b0;
                        end else begin
                            run_cnt_q  <= run_cnt_q + RW'(1);
                            saw_zero_q <= saw_zero_q | ~data_i;
                        end
                    end
                    ST_LOCK: begin
                        run_cnt_q <= run_cnt_q;
                    end
                    default: begin
                        fill_cnt_q <= '0;
                    end
                endcase
            end
        end
    end

    assign sync_o    = sync_q;
    assign stat_oe_o = en_i;
    assign stat_o    = en_i & (~sync_q | err_q);

endmodule

// File: rtl/prbs_rx_check_sva.sv
module prbs_rx_check_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       line_mode_i,
    input logic             en_i,
    input logic             valid_i,
    input logic             cnt_clr_i,
    input logic             stat_o,
    input logic             stat_oe_o,
    input logic             sync_o,
    input logic [CNT_W-1:0] err_cnt_o
);

    // R5
    hunt_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !sync_o) |-> stat_o);

    // R6
    pulse_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && stat_o) |-> $past(valid_i));

    // R9
    mode_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_mode_i != $past(line_mode_i)) |=> !sync_o);

    // R10
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (!stat_o && !stat_oe_o));

    // R11
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&err_cnt_o) && !cnt_clr_i) |=> (&err_cnt_o));

    // R11
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_i |=> (err_cnt_o == '0));

    // R11
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr_i |=> ((err_cnt_o == $past(err_cnt_o)) ||
                        (err_cnt_o == $past(err_cnt_o) + CNT_W'(1))));

    // R12
    idle_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && sync_o && (line_mode_i == $past(line_mode_i))) |=> sync_o);

    // R12
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !cnt_clr_i) |=> $stable(err_cnt_o));

endmodule

bind prbs_rx_check prbs_rx_check_sva #(.CNT_W(CNT_W)) sva_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_mode_i (line_mode_i),
    .en_i        (en_i),
    .valid_i     (valid_i),
    .cnt_clr_i   (cnt_clr_i),
    .stat_o      (stat_o),
    .stat_oe_o   (stat_oe_o),
    .sync_o      (sync_o),
    .err_cnt_o   (err_cnt_o)
);

// File: tb/prbs_rx_check_tb_top.sv
module prbs_rx_check_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    line_mode_i = 2'b01;
    logic          en_i = 1'b1;
    logic          valid_i = 1'b0;
    logic          data_i = 1'b0;
    logic          cnt_clr_i = 1'b0;
    logic          stat_o;
    logic          stat_oe_o;
    logic          sync_o;
    logic [CW-1:0] err_cnt_o;

    logic [22:0]   g = 23'h5A3C96;
    logic          long_m = 1'b0;
    int            n_checks = 0;
    int            n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prbs_rx_check #(.CNT_W(CW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_mode_i (line_mode_i),
        .en_i        (en_i),
        .valid_i     (valid_i),
        .data_i      (data_i),
        .cnt_clr_i   (cnt_clr_i),
        .stat_o      (stat_o),
        .stat_oe_o   (stat_oe_o),
        .sync_o      (sync_o),
        .err_cnt_o   (err_cnt_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic flip);
        logic nb;
        nb = long_m ? ~(g[22] ^ g[17]) : ~(g[14] ^ g[13]);
        g = {g[21:0], nb};
        data_i  = nb ^ flip;
        valid_i = 1'b1;
        @(posedge clk);
        #1;
        valid_i = 1'b0;
    endtask

    task automatic send_good(input int n);
        for (int k = 0; k < n; k++) send_bit(1'b0);
    endtask

    task automatic send_raw(input logic b, input int n);
        for (int k = 0; k < n; k++) begin
            data_i  = b;
            valid_i = 1'b1;
            @(posedge clk);
            #1;
            valid_i = 1'b0;
        end
    endtask

    task automatic set_mode(input logic [1:0] m, input logic lng);
        line_mode_i = m;
        long_m      = lng;
        @(posedge clk);
        #1;
    endtask

    // expects sync to rise exactly on the n-th valid bit from now
    task automatic lock_after(input string tag, input int n);
        send_good(n - 1);
        check({tag, " no early sync"}, int'(sync_o), 0);
        send_good(1);
        check({tag, " sync on time"}, int'(sync_o), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int cnt_before;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        // R5 reset state
        check("R5 stat after reset", int'(stat_o), 1);
        check("R5 sync after reset", int'(sync_o), 0);
        check("R10 oe after reset", int'(stat_oe_o), 1);
        check("R11 count after reset", int'(err_cnt_o), 0);

        // R1 R2 short pattern, T3 mode: 15 + 32 bits
        lock_after("R2 T3", 47);
        check("R6 stat low when locked", int'(stat_o), 0);

        // R6 R7 single error
        send_good(10);
        send_bit(1'b1);
        check("R6 pulse on error", int'(stat_o), 1);
        check("R11 count one", int'(err_cnt_o), 1);
        send_bit(1'b0);
        check("R6 pulse one clock", int'(stat_o), 0);
        send_good(40);
        check("R7 no follow-on errors", int'(err_cnt_o), 1);
        check("R7 still locked", int'(sync_o), 1);

        // R12 idle cycles with garbage data
        for (int k = 0; k < 6; k++) begin
            data_i = k[0];
            @(posedge clk);
            #1;
        end
        check("R12 sync kept while idle", int'(sync_o), 1);
        check("R12 stat quiet while idle", int'(stat_o), 0);
        send_good(30);
        check("R12 pattern not advanced", int'(err_cnt_o), 1);

        // R11 clear
        cnt_clr_i = 1'b1;
        @(posedge clk);
        #1;
        cnt_clr_i = 1'b0;
        check("R11 clear", int'(err_cnt_o), 0);

        // R8 six errors over 65 bits: offsets 0,13,26,39,52,64
        send_good(64);
        for (int k = 0; k < 65; k++)
            send_bit((k % 13 == 0) || (k == 64));
        check("R8 six over 65 keeps sync", int'(sync_o), 1);
        check("R11 six counted", int'(err_cnt_o), 6);

        // R8 six errors over 64 bits: offsets 0,12,24,36,48,63
        send_good(64);
        for (int k = 0; k < 63; k++)
            send_bit((k % 12 == 0) && (k <= 48));
        check("R8 five in window keeps sync", int'(sync_o), 1);
        send_bit(1'b1);
        check("R8 sixth in window loses sync", int'(sync_o), 0);
        check("R5 stat high after loss", int'(stat_o), 1);
        check("R11 saturated", int'(err_cnt_o), 7);
        send_bit(1'b1);
        check("R11 held at all ones", int'(err_cnt_o), 7);
        lock_after("R2 relock", 47);

        // R8 sweep of burst span around the window length
        for (int s = 60; s <= 68; s++) begin
            send_good(64);
            for (int k = 0; k < s; k++)
                send_bit((k < 5) || (k == s - 1));
            check($sformatf("R8 span %0d", s), int'(sync_o), (s <= 64) ? 0 : 1);
            if (s <= 64) lock_after($sformatf("R2 relock span %0d", s), 47);
        end

        // R9 mode change while locked, then R1 STS-1 is short
        set_mode(2'b10, 1'b0);
        check("R9 sync dropped on mode change", int'(sync_o), 0);
        lock_after("R1 STS-1 short", 47);

        // R1 short pattern in E3 mode never locks
        set_mode(2'b00, 1'b0);
        send_good(300);
        check("R1 short stream in E3", int'(sync_o), 0);

        // R1 R2 long pattern: 23 + 32 bits
        set_mode(2'b01, 1'b1);
        set_mode(2'b00, 1'b1);
        lock_after("R2 E3 long", 55);
        set_mode(2'b01, 1'b1);
        send_good(300);
        check("R1 long stream in T3", int'(sync_o), 0);

        // R3 bad bit at index 25 during qualification: lock at index 72
        set_mode(2'b10, 1'b0);
        set_mode(2'b01, 1'b0);
        send_good(25);
        send_bit(1'b1);
        send_good(46);
        check("R3 no sync before restart completes", int'(sync_o), 0);
        send_good(1);
        check("R3 sync after restart", int'(sync_o), 1);

        // R4 all ones never locks
        set_mode(2'b10, 1'b0);
        send_raw(1'b1, 150);
        check("R4 all ones no sync", int'(sync_o), 0);
        check("R4 stat high", int'(stat_o), 1);
        set_mode(2'b01, 1'b0);
        lock_after("R2 after all ones", 47);

        // R10 enable low
        en_i = 1'b0;
        #1;
        check("R10 oe low", int'(stat_oe_o), 0);
        cnt_before = int'(err_cnt_o);
        send_bit(1'b1);
        check("R10 stat zero on error", int'(stat_o), 0);
        check("R10 counting continues", int'(err_cnt_o), (cnt_before == 7) ? 7 : cnt_before + 1);
        set_mode(2'b10, 1'b0);
        check("R10 stat zero out of sync", int'(stat_o), 0);
        en_i = 1'b1;
        #1;
        check("R5 stat high when re-enabled", int'(stat_o), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule